// File: doc/BRIEF.md
# Two-Way Intersection Lamp Sequencer

This block drives the red, yellow and green lamps of a north-south road and an east-west road that meet at one intersection. It runs from a slow tick clock that has already been divided down elsewhere to roughly 0.75 Hz. Every rising edge of that clock is one step of the lamp sequence. A four-phase state machine sets the lamps. Its phases are east-west green, east-west yellow, north-south green and north-south yellow. A small modulo timer decides how long each phase lasts.

With the default parameters the timer counts 0 through 4. Each green phase lasts 4 steps and each yellow phase lasts 1 step. So each road is red for 5 steps, which is exactly the time the other road spends in green plus yellow. The full cycle is 10 steps. All six lamp outputs are active-low: a lamp is lit when its output is 0. A synchronous reset always puts the crossing into east-west green with a freshly started timer. Any state code that is not a legal phase also falls back to east-west green.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: All lamp outputs are active-low (0 = lit). In every step after the first reset edge, exactly one of the three lamps of each road is lit.
- R2: While `rst_sync` is high on a rising edge, the outputs become east-west green and north-south red and stay that way. Written as {ns_red_n, ns_amber_n, ns_go_n, ew_red_n, ew_amber_n, ew_go_n}, this pattern is 6'b011_110.
- R3: After reset is released, east-west green (6'b011_110) is shown for exactly 4 steps and is followed by exactly 1 step of east-west yellow (6'b011_101).
- R4: After east-west yellow comes north-south green (6'b110_011) for 4 steps, then north-south yellow (6'b101_011) for 1 step, then east-west green again. The sequence repeats every 10 steps.
- R5: Each road's red lamp stays lit for an unbroken run of exactly 5 steps per cycle.
- R6: Whenever one road shows green or yellow, the other road's red lamp is lit. The two greens are never lit together.
- R7: A reset asserted in the middle of the sequence (during north-south green or north-south yellow) returns the crossing to east-west green. After release, that green runs its full 4 steps before east-west yellow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tick | input | 1 | Slow step clock, one lamp step per rising edge |
| rst_sync | input | 1 | Synchronous reset, active high |
| ns_red_n | output | 1 | North-south red lamp, active-low |
| ns_amber_n | output | 1 | North-south yellow lamp, active-low |
| ns_go_n | output | 1 | North-south green lamp, active-low |
| ew_red_n | output | 1 | East-west red lamp, active-low |
| ew_amber_n | output | 1 | East-west yellow lamp, active-low |
| ew_go_n | output | 1 | East-west green lamp, active-low |

## Verification
The bench walks two full 10-step cycles against a table of expected lamp patterns, so any off-by-one in the green length, such as leaving a phase at count 2 or 4 instead of 3, shows up as a miscompare at steps 3 to 5 or 8 to 10. It also measures each red run directly. A design that let the timer run on instead of restarting it would give red runs of 4 or 6 steps. The bench resets the block during north-south green and during north-south yellow. If the timer were left stale, east-west green would come back shortened. If the state were reset but not the outputs, the lamps would show the wrong road's pattern. Every sample is also checked for one lamp per road and for conflicting greens, which catches an inverted output polarity or a swapped road decode.

// File: rtl/tl_pkg.sv
package tl_pkg;

  // Phase codes of the sequencer; every 2-bit code is a named phase.
  typedef enum logic [1:0] {
    PH_EW_GO   = 2'd0,
    PH_EW_WARN = 2'd1,
    PH_NS_GO   = 2'd2,
    PH_NS_WARN = 2'd3
  } phase_e;

  // One road's lamps, active-low (0 = lit).
  typedef struct packed {
    logic red_n;
    logic amber_n;
    logic go_n;
  } lamp_t;

  localparam lamp_t LAMP_RED   = '{red_n: 1'b0, amber_n: 1'b1, go_n: 1'b1};
  localparam lamp_t LAMP_AMBER = '{red_n: 1'b1, amber_n: 1'b0, go_n: 1'b1};
  localparam lamp_t LAMP_GO    = '{red_n: 1'b1, amber_n: 1'b1, go_n: 1'b0};

  // Next timer value: count up and wrap to zero at the modulus.
  function automatic int unsigned tick_wrap(input int unsigned cnt,
                                            input int unsigned modulus);
    if (cnt + 1 >= modulus) return 0;
    return cnt + 1;
  endfunction

  // Last count of a green phase.
  function automatic int unsigned go_last(input int unsigned go_ticks);
    return go_ticks - 1;
  endfunction

  // Last count of a yellow phase.
  function automatic int unsigned warn_last(input int unsigned go_ticks,
                                            input int unsigned warn_ticks);
    return go_ticks + warn_ticks - 1;
  endfunction

endpackage

// File: rtl/tl_phase_timer.sv
module tl_phase_timer #(
  parameter int unsigned MODULUS = 5,
  localparam int unsigned CW = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic          clk_tick,
  input  logic          rst_sync,
  input  logic          restart,
  output logic [CW-1:0] count_o
);
  import tl_pkg::*;

  logic [CW-1:0] count_next;

  always_comb begin
    count_next = CW'(tick_wrap(int'(count_o), MODULUS));
  end

  always_ff @(posedge clk_tick) begin
    if (rst_sync || restart) count_o <= '0;
    else                     count_o <= count_next;
  end

  assert_timer_range_R5: assert property (@(posedge clk_tick) disable iff (rst_sync)
    count_o < CW'(MODULUS));

  assert_timer_restart_R7: assert property (@(posedge clk_tick)
    (rst_sync || restart) |=> (count_o == '0));

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm #(
  parameter int unsigned GO_TICKS   = 4,
  parameter int unsigned WARN_TICKS = 1,
  parameter int unsigned CW         = 3
) (
  input  logic            clk_tick,
  input  logic            rst_sync,
  input  logic [CW-1:0]   count_i,
  output tl_pkg::phase_e  phase_o,
  output logic            enter_go
);
  import tl_pkg::*;

  localparam logic [CW-1:0] GO_END   = CW'(go_last(GO_TICKS));
  localparam logic [CW-1:0] WARN_END = CW'(warn_last(GO_TICKS, WARN_TICKS));

  phase_e phase_next;
  logic   go_done;
  logic   warn_done;

  assign go_done   = (phase_o == PH_EW_GO || phase_o == PH_NS_GO) && (count_i == GO_END);
  assign warn_done = (phase_o == PH_EW_WARN || phase_o == PH_NS_WARN) && (count_i == WARN_END);

  always_comb begin
    phase_next = phase_o;
    enter_go   = 1'b0;
    case (phase_o)
      PH_EW_GO:   if (go_done) phase_next = PH_EW_WARN;
      PH_EW_WARN: if (warn_done) begin
                    phase_next = PH_NS_GO;
                    enter_go   = 1'b1;
                  end
      PH_NS_GO:   if (go_done) phase_next = PH_NS_WARN;
      PH_NS_WARN: if (warn_done) begin
                    phase_next = PH_EW_GO;
                    enter_go   = 1'b1;
                  end
      default: begin
        phase_next = PH_EW_GO;
        enter_go   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_tick) begin
    if (rst_sync) phase_o <= PH_EW_GO;
    else          phase_o <= phase_next;
  end

  assert_reset_phase_R2: assert property (@(posedge clk_tick)
    rst_sync |=> (phase_o == PH_EW_GO));

  assert_go_hold_R3: assert property (@(posedge clk_tick) disable iff (rst_sync)
    (phase_o == PH_EW_GO && count_i != GO_END) |=> (phase_o == PH_EW_GO));

  assert_ew_to_ns_R4: assert property (@(posedge clk_tick) disable iff (rst_sync)
    (phase_o == PH_EW_WARN && count_i == WARN_END) |=> (phase_o == PH_NS_GO && count_i == '0));

  assert_ns_to_ew_R4: assert property (@(posedge clk_tick) disable iff (rst_sync)
    (phase_o == PH_NS_WARN && count_i == WARN_END) |=> (phase_o == PH_EW_GO && count_i == '0));

endmodule

// File: rtl/tl_lamp_drive.sv
module tl_lamp_drive (
  input  tl_pkg::phase_e phase_i,
  output tl_pkg::lamp_t  ns_o,
  output tl_pkg::lamp_t  ew_o
);
  import tl_pkg::*;

  always_comb begin
    ns_o = LAMP_RED;
    ew_o = LAMP_RED;
    case (phase_i)
      PH_EW_GO:   ew_o = LAMP_GO;
      PH_EW_WARN: ew_o = LAMP_AMBER;
      PH_NS_GO:   ns_o = LAMP_GO;
      PH_NS_WARN: ns_o = LAMP_AMBER;
      default:    ew_o = LAMP_GO;
    endcase
  end

endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl #(
  parameter int unsigned GO_TICKS   = 4,
  parameter int unsigned WARN_TICKS = 1
) (
  input  logic clk_tick,
  input  logic rst_sync,
  output logic ns_red_n,
  output logic ns_amber_n,
  output logic ns_go_n,
  output logic ew_red_n,
  output logic ew_amber_n,
  output logic ew_go_n
);
  import tl_pkg::*;

  localparam int unsigned MODULUS = GO_TICKS + WARN_TICKS;
  localparam int unsigned CW      = (MODULUS > 1) ? $clog2(MODULUS) : 1;

  logic [CW-1:0] step_count;
  logic          enter_go;
  phase_e        phase;
  lamp_t         ns_lamps;
  lamp_t         ew_lamps;

  tl_phase_timer #(.MODULUS(MODULUS)) u_timer (
    .clk_tick (clk_tick),
    .rst_sync (rst_sync),
    .restart  (enter_go),
    .count_o  (step_count)
  );

  tl_phase_fsm #(.GO_TICKS(GO_TICKS), .WARN_TICKS(WARN_TICKS), .CW(CW)) u_fsm (
    .clk_tick (clk_tick),
    .rst_sync (rst_sync),
    .count_i  (step_count),
    .phase_o  (phase),
    .enter_go (enter_go)
  );

  tl_lamp_drive u_lamps (
    .phase_i (phase),
    .ns_o    (ns_lamps),
    .ew_o    (ew_lamps)
  );

  assign ns_red_n   = ns_lamps.red_n;
  assign ns_amber_n = ns_lamps.amber_n;
  assign ns_go_n    = ns_lamps.go_n;
  assign ew_red_n   = ew_lamps.red_n;
  assign ew_amber_n = ew_lamps.amber_n;
  assign ew_go_n    = ew_lamps.go_n;

  assert_one_lamp_ns_R1: assert property (@(posedge clk_tick) disable iff (rst_sync)
    $countones({~ns_red_n, ~ns_amber_n, ~ns_go_n}) == 1);

  assert_one_lamp_ew_R1: assert property (@(posedge clk_tick) disable iff (rst_sync)
    $countones({~ew_red_n, ~ew_amber_n, ~ew_go_n}) == 1);

  assert_ew_moving_ns_red_R6: assert property (@(posedge clk_tick) disable iff (rst_sync)
    (!ew_go_n || !ew_amber_n) |-> !ns_red_n);

  assert_ns_moving_ew_red_R6: assert property (@(posedge clk_tick) disable iff (rst_sync)
    (!ns_go_n || !ns_amber_n) |-> !ew_red_n);

  assert_no_dual_green_R6: assert property (@(posedge clk_tick) disable iff (rst_sync)
    !(!ns_go_n && !ew_go_n));

  assert_reset_lamps_R2: assert property (@(posedge clk_tick)
    rst_sync |=> (!ew_go_n && !ns_red_n));

endmodule

// File: tb/tl_crossing_ctrl_bench.sv
`timescale 1ns/1ps
module tl_crossing_ctrl_bench;

  logic clk_tick = 1'b0;
  logic rst_sync = 1'b1;
  logic ns_red_n, ns_amber_n, ns_go_n, ew_red_n, ew_amber_n, ew_go_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk_tick = ~clk_tick;

  tl_crossing_ctrl u_tl_crossing_ctrl (
    .clk_tick   (clk_tick),
    .rst_sync   (rst_sync),
    .ns_red_n   (ns_red_n),
    .ns_amber_n (ns_amber_n),
    .ns_go_n    (ns_go_n),
    .ew_red_n   (ew_red_n),
    .ew_amber_n (ew_amber_n),
    .ew_go_n    (ew_go_n)
  );

  // Pattern {ns_red_n, ns_amber_n, ns_go_n, ew_red_n, ew_amber_n, ew_go_n}, 0 = lit.
  localparam logic [5:0] P_EW_GO   = 6'b011_110;
  localparam logic [5:0] P_EW_WARN = 6'b011_101;
  localparam logic [5:0] P_NS_GO   = 6'b110_011;
  localparam logic [5:0] P_NS_WARN = 6'b101_011;

  localparam logic [5:0] EXP_SEQ [10] = '{
    P_EW_GO, P_EW_GO, P_EW_GO, P_EW_GO, P_EW_WARN,
    P_NS_GO, P_NS_GO, P_NS_GO, P_NS_GO, P_NS_WARN
  };

  function automatic logic [5:0] lamps();
    return {ns_red_n, ns_amber_n, ns_go_n, ew_red_n, ew_amber_n, ew_go_n};
  endfunction

  task automatic check6(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: lamps got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_tick);
    @(negedge clk_tick);
  endtask

  // Per-sample rules that hold in every step: R1 and R6.
  task automatic check_rules();
    logic [5:0] p;
    p = lamps();
    check_int("R1 ns one lamp", $countones(~p[5:3]), 1);
    check_int("R1 ew one lamp", $countones(~p[2:0]), 1);
    if (!p[0] || !p[1]) check_int("R6 ns red while ew moving", int'(!p[5]), 1);
    if (!p[3] || !p[4]) check_int("R6 ew red while ns moving", int'(!p[2]), 1);
    check_int("R6 no dual green", int'(!p[3] && !p[0]), 0);
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int ns_run = 0;
    int ew_run = 0;

    // R2: reset held for several edges
    repeat (3) @(posedge clk_tick);
    @(negedge clk_tick);
    check6("R2 reset pattern", lamps(), P_EW_GO);
    rst_sync = 1'b0;

    // Table walk: two full cycles, R3/R4/R5
    for (int i = 0; i < 21; i++) begin
      logic [5:0] p;
      p = lamps();
      check6((i % 10) < 5 ? "R3 ew phase" : "R4 ns phase", p, EXP_SEQ[i % 10]);
      check_rules();
      if (!p[5]) ns_run++;
      else if (ns_run != 0) begin
        check_int("R5 ns red run", ns_run, 5);
        ns_run = 0;
      end
      if (!p[2]) ew_run++;
      else if (ew_run != 0) begin
        check_int("R5 ew red run", ew_run, 5);
        ew_run = 0;
      end
      if (i < 20) step();
    end

    // Now at step 20 (index 0). Advance to north-south green, index 6.
    repeat (6) step();
    check6("R4 ns green before reset", lamps(), P_NS_GO);

    // R7: reset during north-south green
    rst_sync = 1'b1;
    step();
    check6("R7 reset mid ns green", lamps(), P_EW_GO);
    step();
    step();
    check6("R2 reset held", lamps(), P_EW_GO);
    rst_sync = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check6("R7 sequence after reset", lamps(), EXP_SEQ[i]);
      check_rules();
      if (i < 5) step();
    end

    // At index 5; advance to north-south yellow, index 9.
    repeat (4) step();
    check6("R4 ns yellow before reset", lamps(), P_NS_WARN);

    // R7: reset during north-south yellow
    rst_sync = 1'b1;
    step();
    check6("R7 reset mid ns yellow", lamps(), P_EW_GO);
    rst_sync = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check6("R7 full cycle after reset", lamps(), EXP_SEQ[i]);
      check_rules();
      step();
    end
    check6("R4 cycle wraps to ew green", lamps(), P_EW_GO);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule